// File: doc/BRIEF.md
# Modulus Counter Time Base

This block is the time base of one timer channel. It contains an up-counter that runs from 0 up to a programmable match value and then restarts from 0. The counter advances on a count tick. The tick comes either from an internal clock divider, with a ratio of 1 to 4 system clocks, or from rising edges of an external event input, which is first passed through a synchronizer. A sticky flag records every match. Software clears the flag with a write-one strobe.

Three restart styles are available.
- **Clear on match start:** the counter returns to 0 one system clock after it reaches the match value. With an internal tick it then lets one more tick pass before it counts again. With an external tick it counts on the very next event.
- **Clear on match end:** the counter stays at the match value for a full tick period. It returns to 0 on the next tick.
- **PWM frequency:** the counter always clears early and then skips one tick, whatever the tick source.

A channel enable holds the counter at 0 and restarts the divider phase.

Top module: `modulus_timebase`

## Requirements
- R1: With divider ratio 1 and an internal tick (`psc_sel` = 0), the count runs 0, 1, …, M and back to 0. The period is M+1 clocks in every mode.
- R2: With ratio R (`psc_sel` = R-1) in clear-on-match-end mode (`mode_sel` = 1), the count advances once every R clocks. It holds M for R clocks and 0 for R clocks, and the period is (M+1)·R clocks.
- R3: In clear-on-match-start mode (`mode_sel` = 0) with the internal tick, and in PWM frequency mode (`mode_sel` = 2 or 3), the counter shows M for exactly one clock and then clears. One further tick is skipped. The count therefore sits at 0 for 2R-1 clocks, and the period is (M+1)·R clocks.
- R4: In clear-on-match-start mode with the external source (`src_ext` = 1), the counter clears one clock after reaching M. It advances to 1 on the next event, with no skip. Without events it does not move.
- R5: In PWM frequency mode with the external source, the first event after a clear is ignored. The event after that advances the count to 1.
- R6: The external input passes through two synchronizer stages. Each rising edge yields exactly one count, however long the level is held. An input driven high before clock edge n changes the count at edge n+2.
- R7: On the first clock in which the count equals M, the flag is set. The flag is visible one clock later and stays set until it is cleared.
- R8: A one-clock pulse on `flag_clr` clears the flag when no match starts in that clock.
- R9: When a match starts in the same clock as a `flag_clr` pulse, the flag ends up set.
- R10: While `chan_en` is low the count is 0. After `chan_en` rises, the first internal tick comes on the R-th enabled clock.
- R11: A synchronous reset sets the count and the flag to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enable; low holds the count at 0 |
| src_ext | input | 1 | 1 selects the external event as tick source |
| ext_evt | input | 1 | Asynchronous external event input |
| psc_sel | input | PSC_W | Divider ratio minus one |
| mode_sel | input | 2 | 0 clear on match start, 1 clear on match end, 2/3 PWM frequency |
| match_val | input | CNT_W | Match value M |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| cnt | output | CNT_W | Current counter value |
| flag | output | 1 | Sticky match flag |

## Verification
The bench builds the block with a 4-bit counter and a 2-bit divider select. This small configuration lets it sweep every restart style over every divider ratio from 1 to 4 and every match value from 1 to 5. For each case it measures the period and how long the count dwells at 0 and at M, and compares these with (M+1)·R, 2R-1 and R. Directed sequences of external events cover the skip and no-skip restarts, the synchronizer latency, level holding, the flag priority rules and the enable-driven phase restart.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
  typedef enum logic [1:0] {
    TB_MATCH_START  = 2'd0,
    TB_MATCH_END    = 2'd1,
    TB_PWM_FREQ     = 2'd2,
    TB_PWM_FREQ_ALT = 2'd3
  } tb_mode_e;

  // true when the mode clears early and then drops one tick before counting
  function automatic logic skips_tick(tb_mode_e m, logic ext_src);
    return (m == TB_PWM_FREQ) || (m == TB_PWM_FREQ_ALT) ||
           ((m == TB_MATCH_START) && !ext_src);
  endfunction
endpackage

// File: rtl/tbase_prescaler.sv
module tbase_prescaler #(
  parameter int PSC_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PSC_W-1:0] sel,
  output logic             tick
);
  logic [PSC_W-1:0] phase_q;
  logic             wrap;

  assign wrap = (phase_q >= sel);
  assign tick = run && wrap;

  always_ff @(posedge clk) begin
    if (rst || !run) phase_q <= '0;
    else if (wrap)   phase_q <= '0;
    else             phase_q <= phase_q + {{(PSC_W-1){1'b0}}, 1'b1};
  end

  // R2: with a ratio above one, ticks never come back to back
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    (tick && sel != '0) |=> (!tick || sel == '0));
endmodule

// File: rtl/tbase_event_sync.sv
module tbase_event_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic evt_in,
  output logic tick
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= evt_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain_q[STAGES-1];
  end

  assign tick = run && chain_q[STAGES-1] && !last_q;

  // R6: a rising edge yields a single-cycle tick
  a_r6_single_tick: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/tbase_counter.sv
module tbase_counter
  import tbase_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic             src_ext,
  input  tb_mode_e         mode,
  input  logic [CNT_W-1:0] match,
  output logic [CNT_W-1:0] cnt_q,
  output logic             hit
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic skip_q;
  logic seen_q;
  logic at_match;
  logic late_clear;

  assign at_match   = (cnt_q == match);
  assign late_clear = (mode == TB_MATCH_END);
  assign hit        = run && at_match && !seen_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q  <= '0;
      skip_q <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      seen_q <= at_match;
      if (late_clear) begin
        skip_q <= 1'b0;
        if (tick) cnt_q <= at_match ? '0 : cnt_q + ONE;
      end else if (at_match) begin
        cnt_q  <= '0;
        skip_q <= skips_tick(mode, src_ext) && !tick;
      end else if (tick) begin
        if (skip_q) skip_q <= 1'b0;
        else        cnt_q  <= cnt_q + ONE;
      end
    end
  end

  // R3/R4: early-clear modes leave the match value after one clock
  a_r3_clear_after_match: assert property (@(posedge clk) disable iff (rst)
    (run && at_match && !late_clear) |=> (cnt_q == '0));
  // R2: no tick, no movement (unless cleared)
  a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    (run && !tick && !at_match) |=> (cnt_q == $past(cnt_q) || cnt_q == '0));
  // R10: disabled channel sits at zero
  a_r10_hold_zero: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt_q == '0));
endmodule

// File: rtl/modulus_timebase.sv
module modulus_timebase
  import tbase_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PSC_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chan_en,
  input  logic             src_ext,
  input  logic             ext_evt,
  input  logic [PSC_W-1:0] psc_sel,
  input  logic [1:0]       mode_sel,
  input  logic [CNT_W-1:0] match_val,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             flag
);
  logic     int_tick;
  logic     ext_tick;
  logic     tick;
  logic     hit;
  tb_mode_e mode_e;

  assign mode_e = tb_mode_e'(mode_sel);

  tbase_prescaler #(.PSC_W(PSC_W)) i_psc (
    .clk(clk), .rst(rst), .run(chan_en), .sel(psc_sel), .tick(int_tick)
  );

  tbase_event_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .run(chan_en), .evt_in(ext_evt), .tick(ext_tick)
  );

  assign tick = src_ext ? ext_tick : int_tick;

  tbase_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk(clk), .rst(rst), .run(chan_en), .tick(tick), .src_ext(src_ext),
    .mode(mode_e), .match(match_val), .cnt_q(cnt), .hit(hit)
  );

  always_ff @(posedge clk) begin
    if (rst)           flag <= 1'b0;
    else if (hit)      flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end

  // R9: a match start always leaves the flag set
  a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
    hit |=> flag);
  // R7: the flag holds without a clear strobe
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag && !flag_clr) |=> flag);
  // R8: the flag only falls after a clear strobe
  a_r8_clear_source: assert property (@(posedge clk) disable iff (rst)
    $fell(flag) |-> $past(flag_clr));
endmodule

// File: tb/test_modulus_timebase.sv
module test_modulus_timebase;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 4;
  localparam int PW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          chan_en = 1'b0;
  logic          src_ext = 1'b0;
  logic          ext_evt = 1'b0;
  logic [PW-1:0] psc_sel = '0;
  logic [1:0]    mode_sel = 2'd0;
  logic [CW-1:0] match_val = 4'd3;
  logic          flag_clr = 1'b0;
  logic [CW-1:0] cnt;
  logic          flag;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  modulus_timebase #(.CNT_W(CW), .PSC_W(PW), .SYNC_STAGES(2)) i_modulus_timebase (
    .clk(clk), .rst(rst), .chan_en(chan_en), .src_ext(src_ext), .ext_evt(ext_evt),
    .psc_sel(psc_sel), .mode_sel(mode_sel), .match_val(match_val),
    .flag_clr(flag_clr), .cnt(cnt), .flag(flag)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_cnt(input int v);
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (cnt == v) return;
    end
  endtask

  task automatic restart(input int mode, input int ext, input int r, input int m);
    chan_en = 1'b0;
    @(negedge clk);
    mode_sel = mode[1:0]; src_ext = ext[0]; psc_sel = PW'(r - 1); match_val = CW'(m);
    @(negedge clk);
    chan_en = 1'b1;
  endtask

  task automatic pulse_evt();
    ext_evt = 1'b1;
    @(negedge clk);
    ext_evt = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 cnt", cnt, 0);
    check("R11 flag", flag, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R11 cnt after release", cnt, 0);

    // R1 / R2 / R3 sweep: internal tick, all modes, ratios, match values
    for (int mode = 0; mode < 3; mode++) begin
      for (int r = 1; r <= 4; r++) begin
        for (int m = 1; m <= 5; m++) begin
          string tag;
          int per, nm, nz, prev;
          tag = (r == 1) ? "R1" : ((mode == 1) ? "R2" : "R3");
          restart(mode, 0, r, m);
          wait_cnt(m);
          prev = m; nm = 1; nz = 0; per = 0;
          for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            per++;
            if (cnt == m && prev != m) break;
            if (cnt == m) nm++;
            if (cnt == 0) nz++;
            prev = cnt;
          end
          check({tag, " period"}, per, (m + 1) * r);
          check({tag, " dwell at M"}, nm, (mode == 1) ? r : 1);
          check({tag, " dwell at 0"}, nz, (mode == 1) ? r : 2 * r - 1);
        end
      end
    end

    // R4: external source, clear on match start, no skip
    restart(0, 1, 3, 3);
    repeat (8) @(negedge clk);
    check("R4 idle without events", cnt, 0);
    pulse_evt(); check("R4 ev1", cnt, 1);
    pulse_evt(); check("R4 ev2", cnt, 2);
    pulse_evt(); check("R4 ev3 cleared", cnt, 0);
    pulse_evt(); check("R4 ev4 no skip", cnt, 1);
    pulse_evt(); check("R4 ev5", cnt, 2);
    pulse_evt(); check("R4 ev6 cleared", cnt, 0);

    // R5: external source, PWM frequency mode skips one event
    restart(2, 1, 1, 3);
    repeat (4) @(negedge clk);
    pulse_evt(); check("R5 ev1", cnt, 1);
    pulse_evt(); check("R5 ev2", cnt, 2);
    pulse_evt(); check("R5 ev3 cleared", cnt, 0);
    pulse_evt(); check("R5 ev4 skipped", cnt, 0);
    pulse_evt(); check("R5 ev5", cnt, 1);

    // R6: level held counts once; latency of two synchronizer stages
    restart(0, 1, 1, 9);
    repeat (4) @(negedge clk);
    ext_evt = 1'b1;
    repeat (10) @(negedge clk);
    check("R6 held level", cnt, 1);
    ext_evt = 1'b0;
    repeat (5) @(negedge clk);
    check("R6 after release", cnt, 1);
    ext_evt = 1'b1;
    @(negedge clk);
    check("R6 latency edge0", cnt, 1);
    ext_evt = 1'b0;
    @(negedge clk);
    check("R6 latency edge1", cnt, 1);
    @(negedge clk);
    check("R6 latency edge2", cnt, 2);

    // R7 / R8 / R9: flag behaviour (match end mode, R=4, M=2)
    restart(1, 0, 4, 2);
    wait_cnt(0);
    wait_cnt(1);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    check("R8 cleared", flag, 0);
    wait_cnt(2);
    check("R7 not yet set", flag, 0);
    @(negedge clk);
    check("R7 set", flag, 1);
    repeat (12) @(negedge clk);
    check("R7 sticky", flag, 1);
    wait_cnt(0);
    wait_cnt(2);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    check("R9 set wins", flag, 1);
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    check("R8 clear mid-dwell", flag, 0);

    // R10: disable holds zero, phase restarts on enable
    restart(0, 0, 4, 5);
    wait_cnt(3);
    chan_en = 1'b0;
    @(negedge clk);
    check("R10 disabled", cnt, 0);
    repeat (3) @(negedge clk);
    check("R10 still disabled", cnt, 0);
    chan_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 before first tick", cnt, 0);
    @(negedge clk);
    check("R10 first tick", cnt, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule